// File: doc/BRIEF.md
# Conversion Rate Timing Generator

This block produces the periodic start strobe that tells a conversion sequencer when to begin its next sample. It runs from one fixed system clock. Division happens in two stages. A power-of-two prescaler makes a clock enable that stands in for the analog core clock. A second counter then counts a whole conversion, which is a multiple of six of those core ticks. The strobe period in system clock cycles is `prescale × (unit + 1) × 6`.

Software programs the rate through a single 32-bit timer word. A 3-bit code in the top bits of the word picks the prescale, and a low field holds the time unit. A global enable starts and stops the generator. The word may change only while every conversion slot is disabled, so the block ignores a write whenever any slot enable is high. An accepted write restarts both counters, and the next strobe therefore comes a full new period after the write.

Top module: `conv_rate_timer`

## Requirements
- R1: After reset, `startStrobe` is low and the timer word holds prescale code 0 and time unit 1, which gives a period of 48 cycles.
- R2: Bits 31:29 of the timer word are the prescale code. Codes 0, 1, 2, 3, 4 and 5 divide by 4, 8, 16, 32, 64 and 128.
- R3: Prescale codes 6 and 7 divide by 128.
- R4: Bits 7:0 of the timer word are the time unit. Bits 28:8 have no effect on timing.
- R5: While the generator is enabled, strobes repeat every `prescale × (unit + 1) × 6` cycles. Each strobe is high for exactly one cycle.
- R6: After `genEnable` rises, the first strobe is high just after the N-th rising edge at which enable is sampled high, where N is the full period.
- R7: While `genEnable` is low, no strobe occurs and both counters hold at zero. When enable returns, a full period passes before the next strobe.
- R8: A write to the timer word takes effect only when all bits of `slotEnable` are low. Otherwise the write is ignored.
- R9: An accepted write clears both counters. The next strobe follows one full period of the new word, counted from the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerWrEn | input | 1 | Write strobe for the timer word |
| timerWrData | input | 32 | Timer word: prescale code in bits 31:29, time unit in bits 7:0 |
| slotEnable | input | 4 | Enables of the conversion slots; a write is blocked while any bit is high |
| genEnable | input | 1 | Generator enable from the global configuration |
| startStrobe | output | 1 | One-cycle conversion start pulse |

## Verification
The bench programs several prescale codes paired with small time units: the shortest period (code 0, unit 0), the reset default, mid-range codes with larger units, the top legal code, and the two codes beyond it. It measures both the latency to the first strobe and the interval between strobes, so an off-by-one in either stage, a swapped field, or a wrong clamp each gives a distinct count. A word with the middle bits set checks that only the two fields are decoded. Writes made during a running period, writes made while a slot is busy, and a long disabled stretch followed by re-enable separate counter-restart errors from write-gating errors.

// File: rtl/conv_rate_pkg.sv
package conv_rate_pkg;
  // Control strobes passed from the control module to the datapath
  typedef struct packed {
    logic clear;  // zero both counters and the strobe this cycle
    logic run;    // count this cycle
  } rateCtl_t;

  localparam int CORE_TICKS_PER_UNIT = 6;
endpackage

// File: rtl/conv_rate_ctrl.sv
module conv_rate_ctrl
  import conv_rate_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int CODE_W    = 3,
  parameter int CODE_LSB  = 29,
  parameter int UNIT_W    = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = '0,
  parameter logic [UNIT_W-1:0] RESET_UNIT = UNIT_W'(1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [NUM_SLOTS-1:0] slotEnable,
  input  logic                 genEnable,
  output rateCtl_t             ctl,
  output logic [CODE_W-1:0]    preCode,
  output logic [UNIT_W-1:0]    timeUnit
);
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  logic slotBusy;
  logic wrAccept;
  logic unusedMidBits;

  assign slotBusy      = |slotEnable;
  assign wrAccept      = wrEn && !slotBusy;
  assign unusedMidBits = ^wrData[CODE_LSB-1:UNIT_W];

  // Only the two decoded fields are stored
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCode  <= RESET_CODE;
      timeUnit <= RESET_UNIT;
    end else if (wrAccept) begin
      preCode  <= wrData[CODE_MSB:CODE_LSB];
      timeUnit <= wrData[UNIT_W-1:0];
    end
  end

  always_comb begin
    ctl.clear = wrAccept || !genEnable;
    ctl.run   = genEnable && !wrAccept;
  end

  assert_blocked_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && slotBusy) |=> ($stable(preCode) && $stable(timeUnit)));

  assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !slotBusy) |=> (preCode == $past(wrData[CODE_MSB:CODE_LSB])
                             && timeUnit == $past(wrData[UNIT_W-1:0])));
endmodule

// File: rtl/conv_rate_dp.sv
module conv_rate_dp
  import conv_rate_pkg::*;
#(
  parameter int CODE_W       = 3,
  parameter int UNIT_W       = 8,
  parameter int PRE_MIN_LOG2 = 2,
  parameter int PRE_MAX_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  rateCtl_t          ctl,
  input  logic [CODE_W-1:0] preCode,
  input  logic [UNIT_W-1:0] timeUnit,
  output logic              strobe
);
  localparam int PRE_CNT_W  = PRE_MAX_LOG2;
  localparam int CORE_CNT_W = UNIT_W + 3;
  localparam int MAX_SH_RAW = (2 ** CODE_W) - 1 + PRE_MIN_LOG2;

  logic [PRE_CNT_W-1:0]  preCnt;
  logic [PRE_CNT_W-1:0]  preLast;
  logic [PRE_CNT_W:0]    preSpan;
  logic [CORE_CNT_W-1:0] coreCnt;
  logic [CORE_CNT_W-1:0] coreLast;
  logic                  coreTick;
  logic                  coreWrap;
  int                    rawSh;
  int                    shAmt;

  assign rawSh = int'(preCode) + PRE_MIN_LOG2;

  // Clamp only when the code range can exceed the largest divider
  generate
    if (MAX_SH_RAW > PRE_MAX_LOG2) begin : g_clamp
      assign shAmt = (rawSh > PRE_MAX_LOG2) ? PRE_MAX_LOG2 : rawSh;
    end else begin : g_noclamp
      assign shAmt = rawSh;
    end
  endgenerate

  always_comb begin
    preSpan = (PRE_CNT_W + 1)'(1) << shAmt;
    preLast = PRE_CNT_W'(preSpan - (PRE_CNT_W + 1)'(1));
  end

  assign coreLast = ({3'b000, timeUnit} + CORE_CNT_W'(1)) * CORE_CNT_W'(CORE_TICKS_PER_UNIT)
                    - CORE_CNT_W'(1);

  assign coreTick = ctl.run && (preCnt == preLast);
  assign coreWrap = coreTick && (coreCnt == coreLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      coreCnt <= '0;
      strobe  <= 1'b0;
    end else if (ctl.clear) begin
      preCnt  <= '0;
      coreCnt <= '0;
      strobe  <= 1'b0;
    end else begin
      strobe <= coreWrap;
      preCnt <= coreTick ? '0 : preCnt + PRE_CNT_W'(1);
      if (coreTick) coreCnt <= coreWrap ? '0 : coreCnt + CORE_CNT_W'(1);
    end
  end

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (preCnt == '0 && coreCnt == '0 && !strobe));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> !strobe);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLast);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    coreCnt <= coreLast);
endmodule

// File: rtl/conv_rate_timer.sv
module conv_rate_timer
  import conv_rate_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int NUM_SLOTS    = 4,
  parameter int CODE_W       = 3,
  parameter int CODE_LSB     = 29,
  parameter int UNIT_W       = 8,
  parameter int PRE_MIN_LOG2 = 2,
  parameter int PRE_MAX_LOG2 = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 timerWrEn,
  input  logic [WORD_W-1:0]    timerWrData,
  input  logic [NUM_SLOTS-1:0] slotEnable,
  input  logic                 genEnable,
  output logic                 startStrobe
);
  rateCtl_t          ctl;
  logic [CODE_W-1:0] preCode;
  logic [UNIT_W-1:0] timeUnit;

  conv_rate_ctrl #(
    .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W),
    .CODE_LSB(CODE_LSB), .UNIT_W(UNIT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(timerWrEn), .wrData(timerWrData),
    .slotEnable(slotEnable), .genEnable(genEnable),
    .ctl(ctl), .preCode(preCode), .timeUnit(timeUnit)
  );

  conv_rate_dp #(
    .CODE_W(CODE_W), .UNIT_W(UNIT_W),
    .PRE_MIN_LOG2(PRE_MIN_LOG2), .PRE_MAX_LOG2(PRE_MAX_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .preCode(preCode),
    .timeUnit(timeUnit), .strobe(startStrobe)
  );
endmodule

// File: tb/conv_rate_timer_test.sv
module conv_rate_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        timerWrEn = 1'b0;
  logic [31:0] timerWrData = '0;
  logic [3:0]  slotEnable = '0;
  logic        genEnable = 1'b0;
  logic        startStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  conv_rate_timer uut (
    .clk(clk), .rstN(rstN), .timerWrEn(timerWrEn), .timerWrData(timerWrData),
    .slotEnable(slotEnable), .genEnable(genEnable), .startStrobe(startStrobe)
  );

  function automatic int periodOf(int code, int unit);
    int sh;
    sh = (code > 5) ? 5 : code;
    return (4 << sh) * (unit + 1) * 6;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setEnable(bit en);
    @(negedge clk);
    genEnable = en;
  endtask

  task automatic writeWord(logic [31:0] w);
    @(negedge clk);
    timerWrEn = 1'b1;
    timerWrData = w;
    @(negedge clk);
    timerWrEn = 1'b0;
  endtask

  // Count rising edges from the current negedge until the strobe is seen
  task automatic measureFirst(int exp, string req);
    int found = -1;
    for (int n = 1; n <= 2 * exp + 10; n++) begin
      @(posedge clk); #1;
      if (startStrobe) begin found = n; break; end
    end
    check(req, found, exp);
  endtask

  // Called in the strobe cycle: checks the width, then the interval to the next strobe
  task automatic measureNext(int exp, string req);
    int found = -1;
    for (int n = 1; n <= 2 * exp + 10; n++) begin
      @(posedge clk); #1;
      if (n == 1) check({req, " width"}, int'(startStrobe), 0);
      if (startStrobe) begin found = n; break; end
    end
    check(req, found, exp);
  endtask

  task automatic runConfig(int code, int unit, string req);
    int p;
    p = periodOf(code, unit);
    setEnable(0);
    writeWord({3'(code), 21'd0, 8'(unit)});
    setEnable(1);
    measureFirst(p, req);
    measureNext(p, req);
  endtask

  task automatic testReset();
    check("R1 reset strobe", int'(startStrobe), 0);
    setEnable(1);
    measureFirst(48, "R1 default first");
    measureNext(48, "R5 default period");
    setEnable(0);
  endtask

  task automatic testCodes();
    runConfig(0, 0, "R2 code0 unit0");
    runConfig(1, 2, "R2 code1 unit2");
    runConfig(2, 3, "R2 code2 unit3");
    runConfig(3, 0, "R2 code3 unit0");
    runConfig(4, 1, "R2 code4 unit1");
    runConfig(5, 0, "R2 code5 unit0");
    runConfig(6, 0, "R3 code6");
    runConfig(7, 0, "R3 code7");
  endtask

  task automatic testMidBits();
    setEnable(0);
    writeWord(32'h1FFF_FF02);
    setEnable(1);
    measureFirst(72, "R4 mid bits ignored");
    measureNext(72, "R4 period");
  endtask

  task automatic testBlockedWrite();
    setEnable(0);
    writeWord(32'h0000_0000);
    @(negedge clk);
    slotEnable = 4'b0100;
    writeWord(32'hA000_0003);
    @(negedge clk);
    slotEnable = 4'b0000;
    setEnable(1);
    measureFirst(24, "R8 blocked write ignored");
    setEnable(0);
  endtask

  task automatic testMidRunWrite();
    setEnable(0);
    writeWord(32'h0000_0001);
    setEnable(1);
    repeat (30) @(negedge clk);
    writeWord(32'h0000_0000);
    measureFirst(24, "R9 restart after write");
    measureNext(24, "R9 new period");
    setEnable(0);
  endtask

  task automatic testDisable();
    int seen = 0;
    writeWord(32'h0000_0000);
    setEnable(1);
    repeat (20) @(negedge clk);
    genEnable = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(posedge clk); #1;
      if (startStrobe) seen++;
    end
    check("R7 no strobe while disabled", seen, 0);
    setEnable(1);
    measureFirst(24, "R6 full period after re-enable");
    setEnable(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCodes();
    testMidBits();
    testBlockedWrite();
    testMidRunWrite();
    testDisable();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule